// File: doc/BRIEF.md
# I2C Register Target

This block is a two-wire serial bus target that lets an external host read and write a small bank of 8-bit registers. It answers to one fixed 7-bit device address (0x18). Address byte 0x30 opens a write and 0x31 opens a read. The block follows START, REPEATED START and STOP conditions, and it acknowledges the bytes it accepts. A register pointer is loaded by the first byte of every write, and that pointer advances after each data byte, so one transfer can write or read many registers in a row.

The bank holds three kinds of register:
- Two status registers, whose bits are set by single-cycle hardware event pulses and cleared when the host reads them.
- A run of read/write control registers that drive a parallel output bus to the rest of the chip.
- A read-only revision register with a fixed code.

SCL and SDA are brought into the system clock through synchronisers, and every bus edge is found in that clock domain. The block drives SDA through an open-drain style pull-low output.

Top module: `i2cRegTarget`

## Requirements
- R1: An address byte whose upper seven bits equal 0x18 is acknowledged by holding SDA low through the 9th SCL pulse, with bit 0 selecting read (1) or write (0). Any other address gets no acknowledge, and the target ignores the bus until the next START.
- R2: A STOP (SDA rising while SCL is high) returns the target to idle and releases SDA from any state. A START (SDA falling while SCL is high) restarts address reception from any state. Either condition discards a partly received byte.
- R3: In a write, the first byte after the address byte loads the register pointer and is acknowledged. It changes no register.
- R4: Each further write byte is stored at the pointer and acknowledged, and the pointer then advances by one. The pointer wraps from 0xFF to 0x00.
- R5: Eight read/write control registers sit at addresses 0x02 to 0x09 and reset to 0x00. The register at address 0x02+k drives ctrlOut[8k+7:8k].
- R6: Status registers sit at 0x00 (events statusEvt[7:0]) and 0x01 (events statusEvt[15:8]). A high event bit sets the matching status bit, which holds until that register's byte is taken for transmission. At that point the register clears.
- R7: An event bit that is high in the same clock cycle as the clearing read stays set afterwards. Each event is therefore reported exactly once.
- R8: Address 0x0A reads as the revision code 0x42. Addresses 0x0B to 0xFF read as 0x00.
- R9: Writes to 0x00, 0x01, 0x0A and 0x0B to 0xFF are acknowledged and change no register.
- R10: Read bytes are sent MSB first from the pointer, and SDA changes only while SCL is low. The pointer advances after each byte. A host ACK continues the read; a host NACK ends it, and the target then releases SDA.
- R11: A write that sets the pointer, followed by a REPEATED START and a read, returns data starting at that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data level seen on the bus |
| sdaPullLow | output | 1 | High to pull the SDA line low |
| statusEvt | input | 16 | Event pulses; bits [7:0] set status register 0x00, bits [15:8] set 0x01 |
| ctrlOut | output | 64 | Contents of the control registers, 8 bits per register |

## Verification
A hardware event on a status bit and the bus read that clears that status register can land in the same clock cycle. The bench provokes this by sweeping a single-cycle event pulse over a range of offsets after the SCL fall that loads the status byte for transmission. Each sweep step reads the register twice. Whatever the offset, the event bit must appear in exactly one of the two bytes read. An event that shows in neither read was lost to the clear, and one that shows in both was not cleared.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WRITE,
    ST_WRITE_ACK,
    ST_READ,
    ST_READ_ACK
  } busState_t;

  // Strobes from the bus controller to the register datapath.
  typedef struct packed {
    logic       ptrLoad;
    logic       wrEn;
    logic       rdTake;
    logic [7:0] byteVal;
  } regStrobe_t;

endpackage

// File: rtl/i2cBusCtrl.sv
module i2cBusCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h18,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output logic       sdaLow,
  output regStrobe_t strobe
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclChain, sdaChain;
  logic          sclS, sdaS, sclP, sdaP;

  // Input synchronisers; the depth comes from SYNC_STAGES.
  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain[0] <= sclIn;
          sdaChain[0] <= sdaIn;
        end
      end
    end else begin : gSyncMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[LAST-1:0], sclIn};
          sdaChain <= {sdaChain[LAST-1:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclChain[LAST];
  assign sdaS = sdaChain[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  logic startDet, stopDet, sclRise, sclFall;
  assign startDet = sclS && sclP && sdaP && !sdaS;
  assign stopDet  = sclS && sclP && !sdaP && sdaS;
  assign sclRise  = sclS && !sclP;
  assign sclFall  = !sclS && sclP;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg, txReg;
  logic       isRead, firstByte, masterAck, sdaLowQ;

  // Combinational strobes, so a read load and a status clear share one edge.
  always_comb begin
    strobe         = '0;
    strobe.byteVal = shiftReg;
    if (!startDet && !stopDet && sclFall) begin
      if (state == ST_WRITE && bitCnt == 4'd8) begin
        if (firstByte) strobe.ptrLoad = 1'b1;
        else           strobe.wrEn    = 1'b1;
      end
      if (state == ST_ADDR_ACK && isRead)    strobe.rdTake = 1'b1;
      if (state == ST_READ_ACK && masterAck) strobe.rdTake = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      txReg     <= '0;
      isRead    <= 1'b0;
      firstByte <= 1'b0;
      masterAck <= 1'b0;
      sdaLowQ   <= 1'b0;
    end else if (startDet) begin
      state   <= ST_ADDR;
      bitCnt  <= '0;
      sdaLowQ <= 1'b0;
    end else if (stopDet) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      sdaLowQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR, ST_WRITE: begin
          if (sclRise && bitCnt != 4'd8) begin
            shiftReg <= {shiftReg[6:0], sdaS};
            bitCnt   <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCnt <= '0;
            if (state == ST_ADDR) begin
              if (shiftReg[7:1] == DEV_ADDR) begin
                sdaLowQ <= 1'b1;
                isRead  <= shiftReg[0];
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sdaLowQ   <= 1'b1;
              firstByte <= 1'b0;
              state     <= ST_WRITE_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (isRead) begin
              txReg   <= rdData;
              sdaLowQ <= !rdData[7];
              state   <= ST_READ;
            end else begin
              sdaLowQ   <= 1'b0;
              firstByte <= 1'b1;
              state     <= ST_WRITE;
            end
          end
        end
        ST_WRITE_ACK: begin
          if (sclFall) begin
            sdaLowQ <= 1'b0;
            state   <= ST_WRITE;
          end
        end
        ST_READ: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              bitCnt  <= '0;
              sdaLowQ <= 1'b0;
              state   <= ST_READ_ACK;
            end else begin
              txReg   <= {txReg[6:0], 1'b0};
              sdaLowQ <= !txReg[6];
            end
          end
        end
        ST_READ_ACK: begin
          if (sclRise) begin
            masterAck <= !sdaS;
          end else if (sclFall) begin
            if (masterAck) begin
              txReg   <= rdData;
              sdaLowQ <= !rdData[7];
              state   <= ST_READ;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaLow = sdaLowQ;

  // R10: the target changes SDA only while SCL is low.
  assert_sda_moves_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLowQ != $past(sdaLowQ)) |-> !sclS);

  // R2: a STOP leaves the target idle with SDA released.
  assert_stop_idles_R2: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !sdaLowQ));

  // R1: a foreign address is never acknowledged.
  assert_foreign_silent_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && bitCnt == 4'd8 && !startDet && !stopDet &&
     shiftReg[7:1] != DEV_ADDR) |=> !sdaLowQ);

endmodule

// File: rtl/i2cRegBank.sv
module i2cRegBank
  import i2cRegPkg::*;
#(
  parameter int         STAT_COUNT = 2,
  parameter int         NUM_CTRL   = 8,
  parameter logic [7:0] REV_CODE   = 8'h42
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  regStrobe_t              strobe,
  input  logic [STAT_COUNT*8-1:0] statusEvt,
  output logic [7:0]              rdData,
  output logic [NUM_CTRL*8-1:0]   ctrlOut
);

  localparam int         CTRL_BASE = STAT_COUNT;
  localparam logic [7:0] REV_ADDR  = 8'(CTRL_BASE + NUM_CTRL);

  logic [7:0]                  ptr;
  logic [STAT_COUNT-1:0][7:0]  statQ;
  logic [NUM_CTRL-1:0][7:0]    ctrlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.ptrLoad) begin
      ptr <= strobe.byteVal;
    end else if (strobe.wrEn || strobe.rdTake) begin
      ptr <= ptr + 8'd1;
    end
  end

  // Status: a new event wins over the clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
    end else begin
      for (int s = 0; s < STAT_COUNT; s++) begin
        if (strobe.rdTake && ptr == 8'(s)) statQ[s] <= statusEvt[s*8 +: 8];
        else                               statQ[s] <= statQ[s] | statusEvt[s*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else begin
      for (int c = 0; c < NUM_CTRL; c++) begin
        if (strobe.wrEn && ptr == 8'(CTRL_BASE + c)) ctrlQ[c] <= strobe.byteVal;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int s = 0; s < STAT_COUNT; s++) begin
      if (ptr == 8'(s)) rdData = statQ[s];
    end
    for (int c = 0; c < NUM_CTRL; c++) begin
      if (ptr == 8'(CTRL_BASE + c)) rdData = ctrlQ[c];
    end
    if (ptr == REV_ADDR) rdData = REV_CODE;
  end

  assign ctrlOut = ctrlQ;

  logic ptrIsCtrl;
  assign ptrIsCtrl = (ptr >= 8'(CTRL_BASE)) && (ptr < REV_ADDR);

  // R3: the pointer byte lands in the pointer.
  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ptrLoad |=> ptr == $past(strobe.byteVal));

  // R4: each data byte advances the pointer by one, wrapping.
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn || strobe.rdTake) |=> ptr == $past(ptr) + 8'd1);

  // R7: an event in the clearing cycle survives the clear.
  assert_event_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdTake && ptr == 8'd0) |=> statQ[0] == $past(statusEvt[7:0]));

  // R9: a write to a read-only or unmapped address leaves the controls alone.
  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !ptrIsCtrl) |=> $stable(ctrlQ));

endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h18,
  parameter int         SYNC_STAGES = 2,
  parameter int         STAT_COUNT  = 2,
  parameter int         NUM_CTRL    = 8,
  parameter logic [7:0] REV_CODE    = 8'h42
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  output logic                    sdaPullLow,
  input  logic [STAT_COUNT*8-1:0] statusEvt,
  output logic [NUM_CTRL*8-1:0]   ctrlOut
);

  regStrobe_t strobe;
  logic [7:0] rdData;

  i2cBusCtrl #(
    .DEV_ADDR   (DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rdData(rdData),
    .sdaLow(sdaPullLow),
    .strobe(strobe)
  );

  i2cRegBank #(
    .STAT_COUNT(STAT_COUNT),
    .NUM_CTRL  (NUM_CTRL),
    .REV_CODE  (REV_CODE)
  ) uBank (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .statusEvt(statusEvt),
    .rdData   (rdData),
    .ctrlOut  (ctrlOut)
  );

endmodule

// File: tb/i2cRegTarget_test.sv
module i2cRegTarget_test;

  localparam int HP = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaPullLow;
  logic [15:0] statusEvt = '0;
  logic [63:0] ctrlOut;
  wire         sdaBus = sdaM & ~sdaPullLow;

  always #4 clk = ~clk;

  i2cRegTarget uut (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclM),
    .sdaIn     (sdaBus),
    .sdaPullLow(sdaPullLow),
    .statusEvt (statusEvt),
    .ctrlOut   (ctrlOut)
  );

  int   tests = 0;
  int   fails = 0;
  logic cmpEn = 1'b0;
  logic [7:0] expCtrl [8];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expFlat();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = expCtrl[i];
    return v;
  endfunction

  // R5: control outputs follow the behavioural model on every clock.
  always @(negedge clk) if (cmpEn) check("R5 per-clock ctrlOut", ctrlOut, expFlat());

  task automatic waitC(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; waitC(HP/2);
    sclM = 1'b1; waitC(HP);
    sdaM = 1'b0; waitC(HP);
    sclM = 1'b0; waitC(HP/2);
  endtask

  task automatic stopC();
    sdaM = 1'b0; waitC(HP/2);
    sclM = 1'b1; waitC(HP);
    sdaM = 1'b1; waitC(HP);
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i >= 8 - n; i--) begin
      sdaM = b[i]; waitC(HP/2);
      sclM = 1'b1; waitC(HP);
      sclM = 1'b0; waitC(HP/2);
    end
  endtask

  task automatic pulseEvt(int k);
    waitC(k);
    statusEvt[0] = 1'b1;
    waitC(1);
    statusEvt[0] = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] b, output logic ack, input int pulseAt = -1);
    sendBits(b, 8);
    sdaM = 1'b1; waitC(HP/2);
    sclM = 1'b1; waitC(HP/2);
    ack = !sdaBus;
    waitC(HP/2);
    sclM = 1'b0;
    if (pulseAt >= 0) fork pulseEvt(pulseAt); join_none
    waitC(HP/2);
  endtask

  task automatic recvByte(logic giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      waitC(HP/2); sclM = 1'b1;
      waitC(HP/2); b = {b[6:0], sdaBus};
      waitC(HP/2); sclM = 1'b0;
      waitC(HP/2);
    end
    sdaM = giveAck ? 1'b0 : 1'b1; waitC(HP/2);
    sclM = 1'b1; waitC(HP);
    sclM = 1'b0; waitC(2);
    sdaM = 1'b1; waitC(HP/2 - 2);
  endtask

  task automatic writeRegs(logic [7:0] ptr, logic [7:0] data[$]);
    logic ack;
    logic [7:0] p;
    startC();
    sendByte(8'h30, ack); check("R1 write address ack", ack, 1'b1);
    sendByte(ptr, ack);   check("R3 pointer byte ack", ack, 1'b1);
    p = ptr;
    foreach (data[i]) begin
      cmpEn = 1'b0;
      sendByte(data[i], ack);
      check("R4 data byte ack", ack, 1'b1);
      if (p >= 8'h02 && p <= 8'h09) expCtrl[p - 8'h02] = data[i];
      p = p + 8'd1;
      cmpEn = 1'b1;
    end
    stopC();
  endtask

  task automatic readRegs(logic [7:0] ptr, int n, output logic [7:0] q[$], input int pulseAt = -1);
    logic ack;
    logic [7:0] b;
    q = {};
    startC();
    sendByte(8'h30, ack); check("R11 write address ack", ack, 1'b1);
    sendByte(ptr, ack);   check("R11 pointer ack", ack, 1'b1);
    startC();
    sendByte(8'h31, ack, pulseAt); check("R1 read address ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      q.push_back(b);
    end
    check("R10 SDA released after NACK", sdaPullLow, 1'b0);
    stopC();
  endtask

  logic done = 1'b0;

  initial begin
    waitC(190000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] q2[$];
    logic ack;
    for (int i = 0; i < 8; i++) expCtrl[i] = 8'h00;
    waitC(5);
    rstN = 1'b1;
    waitC(5);
    check("R5 reset ctrlOut", ctrlOut, 64'h0);
    check("R1 reset SDA released", sdaPullLow, 1'b0);
    cmpEn = 1'b1;

    // R4 R5: burst write from 0x02
    writeRegs(8'h02, '{8'h11, 8'h22, 8'h33});
    check("R5 burst write ctrlOut", ctrlOut, expFlat());

    // R1: foreign address ignored
    startC();
    sendByte(8'h52, ack); check("R1 foreign address no ack", ack, 1'b0);
    sendByte(8'h02, ack); check("R1 ignored pointer no ack", ack, 1'b0);
    sendByte(8'hEE, ack); check("R1 ignored data no ack", ack, 1'b0);
    stopC();
    check("R1 foreign transfer no effect", ctrlOut, expFlat());

    // R11 R10: repeated start read burst
    readRegs(8'h02, 3, q);
    check("R11 read byte0", q[0], 8'h11);
    check("R10 read byte1", q[1], 8'h22);
    check("R10 read byte2", q[2], 8'h33);

    // R6: status set and clear-on-read
    statusEvt = 16'h8005; waitC(1); statusEvt = 16'h0000; waitC(4);
    readRegs(8'h00, 2, q);
    check("R6 status0 value", q[0], 8'h05);
    check("R6 status1 value", q[1], 8'h80);
    readRegs(8'h00, 2, q);
    check("R6 status0 cleared", q[0], 8'h00);
    check("R6 status1 cleared", q[1], 8'h00);

    // R7: event swept across the clearing cycle is reported exactly once
    for (int k = 0; k < 9; k++) begin
      readRegs(8'h00, 1, q, k);
      waitC(4);
      readRegs(8'h00, 1, q2);
      check($sformatf("R7 event offset %0d seen once", k), 64'(q[0][0] ^ q2[0][0]), 64'h1);
      check($sformatf("R7 event offset %0d not doubled", k), 64'(q[0][0] & q2[0][0]), 64'h0);
    end

    // R8: revision and unmapped reads
    readRegs(8'h0A, 2, q);
    check("R8 revision code", q[0], 8'h42);
    check("R8 unmapped reads zero", q[1], 8'h00);

    // R9: read-only writes acked and ignored
    statusEvt = 16'h0003; waitC(1); statusEvt = 16'h0000; waitC(4);
    writeRegs(8'h00, '{8'hFF});
    writeRegs(8'h0A, '{8'h99, 8'h77});
    check("R9 ctrl untouched", ctrlOut, expFlat());
    readRegs(8'h00, 1, q);
    check("R9 status not written", q[0], 8'h03);
    readRegs(8'h0A, 1, q);
    check("R9 revision not written", q[0], 8'h42);

    // R4: pointer wrap 0xFF -> 0x00 .. 0x02
    writeRegs(8'hFF, '{8'h01, 8'h02, 8'h03, 8'hC4});
    check("R4 wrap lands on 0x02", ctrlOut[7:0], 8'hC4);

    // R2: STOP in mid byte aborts it
    startC();
    sendByte(8'h30, ack);
    sendByte(8'h03, ack);
    sendBits(8'hF0, 4);
    stopC();
    check("R2 STOP mid-byte no write", ctrlOut, expFlat());
    check("R2 STOP releases SDA", sdaPullLow, 1'b0);

    // R2: START in mid byte restarts address reception
    startC();
    sendByte(8'h30, ack);
    sendBits(8'hA0, 3);
    startC();
    sendByte(8'h30, ack); check("R2 restart address ack", ack, 1'b1);
    sendByte(8'h04, ack);
    cmpEn = 1'b0;
    sendByte(8'h5A, ack);
    expCtrl[2] = 8'h5A;
    cmpEn = 1'b1;
    stopC();
    check("R2 write after restart", ctrlOut[23:16], 8'h5A);

    waitC(10);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule